// File: doc/BRIEF.md
# Prefix-Extended Byte Store Unit

This block executes a 16-bit store-byte instruction. The instruction writes the low eight bits of a source register to memory, at an address taken from a base register. One or two prefix words can come just before the store, and each carries an immediate. One prefix gives a 13-bit zero-extended displacement. Two prefixes together give a 24-bit displacement. The displacement is added to the base to form the address. Registers and addresses are 24 bits wide, and address arithmetic wraps modulo 2^24.

The unit decodes each valid instruction word. It drives the two register read indices combinationally, and it issues a one-cycle byte write on its memory port in the cycle after the store is presented. A prefix-state machine holds the collected immediates. It has three states:

- `PX_NONE`: no prefix is held.
- `PX_ONE`: one 13-bit immediate is held.
- `PX_TWO`: both the high 11 bits and the low 13 bits are held.

The transitions are:

- `T_FIRST`: a prefix arriving in `PX_NONE` or `PX_TWO` moves the machine to `PX_ONE`.
- `T_SECOND`: a prefix arriving in `PX_ONE` moves the machine to `PX_TWO`.
- `T_CONSUME`: a store moves any state to `PX_NONE`.
- `T_FLUSH`: any other valid word moves any state to `PX_NONE`.
- `T_HOLD`: when no valid word arrives, the state does not change.

When the store sits in a branch delay slot, the held displacement is not applied.

Top module: `pfx_byte_store`

## Requirements
- R1: A valid word is a store when bits 15:10 are 001001 and bits 6:3 are 0000. `rf_src_idx` carries bits 9:7 and `rf_base_idx` carries bits 2:0, combinationally.
- R2: The write data equals bits 7:0 of the source register, as read in the cycle the store was presented.
- R3: A store with no prefix held writes to the address equal to the base register value.
- R4: A prefix is a valid word with bits 15:13 equal to 110, and its bits 12:0 are the immediate. With one prefix held, the address is the base plus the zero-extended immediate, modulo 2^24.
- R5: With two prefixes held, the address is the base plus {bits 10:0 of the first immediate, the 13-bit second immediate}, modulo 2^24.
- R6: `mem_wr_en` is high for exactly the one cycle after the cycle a valid store is presented, and it is low otherwise.
- R7: A store presented with `in_delay_slot` high writes to the address equal to the base, whatever prefix is held, and it clears the prefix state.
- R8: Any other valid word clears the prefix state and produces no write. This includes an opcode match with nonzero bits 6:3.
- R9: A cycle with `instr_valid` low leaves the prefix state unchanged and produces no write.
- R10: A prefix arriving while two prefixes are held starts a new sequence as a single prefix.
- R11: A store consumes the prefix state, so a following store with no new prefix uses the base alone.
- R12: During and just after reset, `mem_wr_en` is low and no prefix is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 16 | Instruction word |
| in_delay_slot | input | 1 | Current word sits in a branch delay slot |
| rf_src_idx | output | 3 | Register read index for the source |
| rf_base_idx | output | 3 | Register read index for the base |
| rf_src_data | input | 24 | Source register value |
| rf_base_data | input | 24 | Base register value |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wr_addr | output | 24 | Byte write address |
| mem_wr_data | output | 8 | Byte write data |

## Verification
The bench targets the following corner cases:

- **Wraparound.** A base near the top of the address space plus a displacement must wrap to a small address. A sign-extending or width-truncating adder would produce an address far off.
- **Stale prefix.** A prefix followed by a bubble, then by a non-store word or by a malformed store (bits 6:3 nonzero), must leave a later store unextended. Otherwise the old displacement leaks into the next store.
- **Third prefix.** A third consecutive prefix must restart the sequence rather than shift the immediates. If it shifted, the next store would get a 24-bit offset where a 13-bit one is expected.
- **Delay slot.** A delay-slot store must ignore a held displacement. If it did not, the store would land at base plus offset.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
    typedef enum logic [1:0] {
        PX_NONE = 2'd0,
        PX_ONE  = 2'd1,
        PX_TWO  = 2'd2
    } pfx_state_e;

    typedef enum logic [1:0] {
        K_OTHER  = 2'd0,
        K_PREFIX = 2'd1,
        K_STORE  = 2'd2
    } instr_kind_e;

    localparam logic [5:0] STORE_OPC  = 6'b001001;
    localparam logic [2:0] PREFIX_OPC = 3'b110;
endpackage

// File: rtl/pbs_decode.sv
module pbs_decode
    import pbs_pkg::*;
#(
    parameter int IW     = 16,
    parameter int RIDX_W = 3,
    parameter int IMM_W  = 13
) (
    input  logic [IW-1:0]     word,
    output instr_kind_e       kind,
    output logic [RIDX_W-1:0] src_idx,
    output logic [RIDX_W-1:0] base_idx,
    output logic [IMM_W-1:0]  imm
);
    always_comb begin
        src_idx  = word[9:7];
        base_idx = word[2:0];
        imm      = word[IMM_W-1:0];
        if (word[15:13] == PREFIX_OPC)
            kind = K_PREFIX;
        else if (word[15:10] == STORE_OPC && word[6:3] == 4'b0000)
            kind = K_STORE;
        else
            kind = K_OTHER;
    end
endmodule

// File: rtl/pbs_prefix_fsm.sv
module pbs_prefix_fsm
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IMM_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  instr_kind_e       kind,
    input  logic [IMM_W-1:0]  imm,
    output pfx_state_e        state,
    output logic [ADDR_W-1:0] disp
);
    // High part of a two-prefix displacement; taken from the first immediate,
    // so it must not be wider than IMM_W.
    localparam int HI_W = ADDR_W - IMM_W;

    pfx_state_e       nxt;
    logic [HI_W-1:0]  hi_q;
    logic [IMM_W-1:0] lo_q;

    // Next-state logic
    always_comb begin
        nxt = state;
        if (valid) begin
            unique case (kind)
                K_PREFIX: nxt = (state == PX_ONE) ? PX_TWO : PX_ONE; // T_SECOND / T_FIRST
                K_STORE:  nxt = PX_NONE;                             // T_CONSUME
                default:  nxt = PX_NONE;                             // T_FLUSH
            endcase
        end
    end

    // State register and immediate latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PX_NONE;
            hi_q  <= '0;
            lo_q  <= '0;
        end else begin
            state <= nxt;
            if (valid && kind == K_PREFIX) begin
                if (state == PX_ONE)
                    hi_q <= lo_q[HI_W-1:0];
                lo_q <= imm;
            end
        end
    end

    // Displacement output per state
    always_comb begin
        unique case (state)
            PX_ONE:  disp = ADDR_W'(lo_q);
            PX_TWO:  disp = {hi_q, lo_q};
            default: disp = '0;
        endcase
    end

    AST_TWO_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind == K_PREFIX && state == PX_ONE) |=> state == PX_TWO); // R5
    AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind == K_STORE) |=> state == PX_NONE); // R11
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind == K_OTHER) |=> state == PX_NONE); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(state)); // R9
    AST_THIRD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && kind == K_PREFIX && state == PX_TWO) |=> state == PX_ONE); // R10
endmodule

// File: rtl/pbs_agu.sv
module pbs_agu #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] disp,
    input  logic              bypass,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = base + (bypass ? '0 : disp);
    end
endmodule

// File: rtl/pfx_byte_store.sv
module pfx_byte_store
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int IMM_W  = 13,
    parameter int RIDX_W = 3,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr_word,
    input  logic              in_delay_slot,
    output logic [RIDX_W-1:0] rf_src_idx,
    output logic [RIDX_W-1:0] rf_base_idx,
    input  logic [ADDR_W-1:0] rf_src_data,
    input  logic [ADDR_W-1:0] rf_base_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [BYTE_W-1:0] mem_wr_data
);
    instr_kind_e       kind;
    pfx_state_e        pstate;
    logic [IMM_W-1:0]  imm;
    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] eff_addr;
    logic              store_fire;

    pbs_decode #(.IW(16), .RIDX_W(RIDX_W), .IMM_W(IMM_W)) u_dec (
        .word     (instr_word),
        .kind     (kind),
        .src_idx  (rf_src_idx),
        .base_idx (rf_base_idx),
        .imm      (imm)
    );

    pbs_prefix_fsm #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (instr_valid),
        .kind  (kind),
        .imm   (imm),
        .state (pstate),
        .disp  (disp)
    );

    pbs_agu #(.ADDR_W(ADDR_W)) u_agu (
        .base   (rf_base_data),
        .disp   (disp),
        .bypass (in_delay_slot),
        .addr   (eff_addr)
    );

    assign store_fire = instr_valid && (kind == K_STORE);

    // Registered write stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr_en   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
        end else begin
            mem_wr_en <= store_fire;
            if (store_fire) begin
                mem_wr_addr <= eff_addr;
                mem_wr_data <= rf_src_data[BYTE_W-1:0];
            end
        end
    end

    AST_WR_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(instr_valid && kind == K_STORE)); // R6
    AST_NO_WR_NONSTORE: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid && kind == K_STORE) |=> !mem_wr_en); // R8
    AST_DS_BASE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && kind == K_STORE && in_delay_slot) |=> mem_wr_addr == $past(rf_base_data)); // R7
    AST_WR_DATA_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> mem_wr_data == $past(rf_src_data[BYTE_W-1:0])); // R2
endmodule

// File: tb/pfx_byte_store_tb.sv
module pfx_byte_store_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        in_delay_slot = 1'b0;
    logic [2:0]  rf_src_idx, rf_base_idx;
    logic [23:0] rf_src_data, rf_base_data;
    logic        mem_wr_en;
    logic [23:0] mem_wr_addr;
    logic [7:0]  mem_wr_data;

    logic [23:0] regs [8];
    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Bench model of the prefix state
    int          m_state = 0;
    logic [10:0] m_hi = '0;
    logic [12:0] m_lo = '0;

    always #5 clk = ~clk;

    assign rf_src_data  = regs[rf_src_idx];
    assign rf_base_data = regs[rf_base_idx];

    pfx_byte_store u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .in_delay_slot(in_delay_slot), .rf_src_idx(rf_src_idx), .rf_base_idx(rf_base_idx),
        .rf_src_data(rf_src_data), .rf_base_data(rf_base_data), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    function automatic logic [23:0] exp_addr(logic [23:0] base, int st,
                                             logic [10:0] hi, logic [12:0] lo, logic ds);
        logic [23:0] d;
        if (ds || st == 0) d = '0;
        else if (st == 1)  d = {11'b0, lo};
        else               d = {hi, lo};
        return base + d;
    endfunction

    function automatic logic [15:0] mk_store(logic [2:0] s, logic [2:0] b);
        return {6'b001001, s, 4'b0000, b};
    endfunction

    function automatic logic [15:0] mk_pfx(logic [12:0] i);
        return {3'b110, i};
    endfunction

    task automatic check(string tag, logic [23:0] act, logic [23:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Present one word at a negedge, then check the outputs one negedge later
    task automatic issue(logic v, logic [15:0] w, logic ds, string tag);
        logic        is_store, is_pfx;
        logic [23:0] ea;
        logic [7:0]  ed;
        instr_valid = v; instr_word = w; in_delay_slot = ds;
        is_pfx   = (w[15:13] == 3'b110);
        is_store = !is_pfx && w[15:10] == 6'b001001 && w[6:3] == 4'b0000;
        #1;
        if (v && is_store) begin
            check("R1 src idx", {21'b0, rf_src_idx}, {21'b0, w[9:7]});
            check("R1 base idx", {21'b0, rf_base_idx}, {21'b0, w[2:0]});
        end
        ea = exp_addr(regs[w[2:0]], m_state, m_hi, m_lo, ds);
        ed = regs[w[9:7]][7:0];
        if (v) begin
            if (is_pfx) begin
                if (m_state == 1) begin m_hi = m_lo[10:0]; m_lo = w[12:0]; m_state = 2; end
                else begin m_lo = w[12:0]; m_state = 1; end
            end else m_state = 0;
        end
        @(negedge clk);
        check({"R6 strobe ", tag}, {23'b0, mem_wr_en}, {23'b0, v && is_store});
        if (v && is_store) begin
            check({tag, " addr"}, mem_wr_addr, ea);
            check("R2 data", {16'b0, mem_wr_data}, {16'b0, ed});
        end
    endtask

    function automatic string store_tag(logic ds);
        if (ds) return "R7";
        if (m_state == 2) return "R5";
        if (m_state == 1) return "R4";
        return "R3";
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 8; i++) regs[i] = $urandom() & 24'hFFFFFF;
        repeat (3) @(negedge clk);
        check("R12 strobe in reset", {23'b0, mem_wr_en}, 24'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 strobe after reset", {23'b0, mem_wr_en}, 24'd0);
        issue(1, mk_store(3'd1, 3'd2), 0, "R12 no prefix");

        // Wraparound with one prefix
        regs[3] = 24'hFFFFF0; regs[4] = 24'h0000AB;
        issue(1, mk_pfx(13'h0020), 0, "R4");
        issue(1, mk_store(3'd4, 3'd3), 0, "R4 wrap");
        // R11: a second store without prefix
        issue(1, mk_store(3'd4, 3'd3), 0, "R11");
        // Two prefixes with wrap
        issue(1, mk_pfx(13'h1FFF), 0, "R5");
        issue(1, mk_pfx(13'h0011), 0, "R5");
        issue(1, mk_store(3'd4, 3'd3), 0, "R5");
        // R10: three prefixes
        issue(1, mk_pfx(13'h0101), 0, "R10");
        issue(1, mk_pfx(13'h0202), 0, "R10");
        issue(1, mk_pfx(13'h0003), 0, "R10");
        issue(1, mk_store(3'd4, 3'd3), 0, "R10");
        // R9: bubble keeps prefix
        issue(1, mk_pfx(13'h0040), 0, "R9");
        issue(0, mk_store(3'd4, 3'd3), 0, "R9");
        issue(1, mk_store(3'd4, 3'd3), 0, "R9");
        // R8: malformed store flushes, then store unextended
        issue(1, mk_pfx(13'h0050), 0, "R8");
        issue(1, 16'h2488, 0, "R8");
        issue(1, mk_store(3'd4, 3'd3), 0, "R8");
        // R7: delay slot ignores held displacement and clears it
        issue(1, mk_pfx(13'h0070), 0, "R7");
        issue(1, mk_store(3'd4, 3'd3), 1, "R7");
        issue(1, mk_store(3'd4, 3'd3), 0, "R7");

        // Constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] w;
            logic v, ds;
            int cat;
            if ($urandom_range(0, 9) == 0) regs[$urandom_range(0, 7)] = $urandom() & 24'hFFFFFF;
            v   = ($urandom_range(0, 99) < 85);
            ds  = ($urandom_range(0, 4) == 0);
            cat = $urandom_range(0, 9);
            w   = 16'($urandom());
            if (cat < 4)      w = mk_store(w[9:7], w[2:0]);
            else if (cat < 7) w = mk_pfx(w[12:0]);
            else if (cat < 8) begin w[15:10] = 6'b001001; if (w[6:3] == 4'b0) w[3] = 1'b1; end
            else if (w[15:13] == 3'b110 || w[15:10] == 6'b001001) w[15:13] = 3'b000;
            if (w[15:13] != 3'b110 && w[15:10] == 6'b001001 && w[6:3] == 4'b0)
                issue(v, w, ds, v ? store_tag(ds) : "R9");
            else
                issue(v, w, ds, v ? "R8" : "R9");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule